// File: doc/BRIEF.md
# Two-Wire Addressed Byte Memory Target

This block is a target device on a two-wire serial bus (SCL clock, SDA open-drain data) that fronts a byte-wide memory held inside the block. A fast system clock oversamples both bus lines. The block recognises Start and Stop conditions and decodes a device-select byte. It loads a memory pointer from two address bytes and then streams data bytes into or out of the array. The pointer steps by one after every byte and wraps to zero at the top of the array. It keeps its value between transactions, so a read that is not preceded by an address phase continues from where the last access stopped. SDA is never driven high. The output `sda_oe` asks the pad to pull the line low.

Reads are prepared ahead of time. The synchronous array is always addressed by the pointer, so the byte to send is already registered when its first bit must go out. Writes land in the array only once the eighth bit of a byte has been sampled. A Start or Stop that arrives before that bit discards the byte. When `wp` is high, the upper quarter of the address space refuses writes: such a byte is not acknowledged and the pointer stays put. The pointer is `ADDR_W` bits wide, with a default of 11 (2048 bytes). Setting `ADDR_W` to 13 gives the full 8 KiB array, with wrap from 1FFFh and protection of 1800h to 1FFFh.

The controller is one state machine:

- `S_IDLE`: bus free.
- `S_DEV`: receive the select byte.
- `S_AHI` and `S_ALO`: receive the upper and lower address bytes.
- `S_WR`: receive a data byte.
- `S_ACK1`: wait for SCL low before the acknowledge slot.
- `S_ACK2`: drive the acknowledge slot.
- `S_RD`: shift out a byte.
- `S_RACK`: sample the controller's acknowledge.
- `S_RLD`: wait to load the next read byte.
- `S_IGN`: stay silent until the next Start or Stop.

The transitions are as follows:

- Start from any state goes to `S_DEV`.
- Stop from any state goes to `S_IDLE`.
- `S_DEV` goes to `S_ACK1` on a match and to `S_IGN` otherwise.
- `S_AHI`, `S_ALO` and `S_WR` go to `S_ACK1` after eight bits.
- `S_ACK1` goes to `S_ACK2` when SCL falls.
- When SCL falls in `S_ACK2`, the machine goes to the state stored during the byte: `S_AHI`, `S_ALO`, `S_WR`, `S_RD` or `S_IGN`.
- `S_RD` goes to `S_RACK` after eight bits.
- `S_RACK` goes to `S_RLD` on ACK and to `S_IGN` on NACK.
- `S_RLD` goes to `S_RD` when SCL falls.

Top module: `i2cmem_slave`

## Requirements
- R1: A select byte whose bits 7..4 are 1010 and bits 3..1 equal `chip_sel` is acknowledged. Bit 0 picks the direction, with 0 meaning write and 1 meaning read. Any other select byte gets no acknowledge, and all bytes that follow are neither acknowledged nor acted on until the next Start or Stop.
- R2: After a write select, the next two bytes load the pointer, upper byte first. Upper-byte bits at position ADDR_W-8 and above are ignored.
- R3: Each write data byte is stored at the pointer and acknowledged, and the pointer then steps by one. It wraps from 2^ADDR_W-1 to 0.
- R4: A read sends the byte at the pointer MSB first and steps the pointer. On ACK from the controller the next byte follows. On NACK, SDA stays released.
- R5: The pointer persists across transactions. A read started without an address phase begins at it. Address bytes followed by a repeated Start and a read select perform a random read and write nothing.
- R6: A Start or Stop before the eighth bit of a data byte leaves both the array and the pointer unchanged.
- R7: With `wp` high, a data byte aimed at the upper quarter (the two top pointer bits equal 11) is not acknowledged, not stored, and leaves the pointer unchanged. With `wp` low, those addresses are writable.
- R8: A select byte sent immediately after a write, via a repeated Start, is acknowledged.
- R9: After reset SDA is released. The block only ever pulls SDA low, and it changes its drive only while SCL is low, except for releasing on Start or Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| chip_sel | input | 3 | Strapped select value compared against select bits 3..1 |
| wp | input | 1 | Write-protect for the upper quarter of the array |

## Verification
On every cycle the embedded properties check the following:

- drive changes happen only while SCL is low;
- the block is silent in the ignore and acknowledge-sampling states;
- the pointer only ever steps by one or is loaded from the address phase;
- a refused protected write leaves the pointer still.

Whether the right byte comes back, whether an aborted byte really left the array untouched, and whether the pointer survives across Stops can only be shown by the bench. It replays directed and random bus transactions against a model of the array and pointer.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_AHI,
        S_ALO,
        S_WR,
        S_ACK1,
        S_ACK2,
        S_RD,
        S_RACK,
        S_RLD,
        S_IGN
    } state_t;

    localparam logic [3:0] SEL_CODE = 4'b1010;

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cmem_cond.sv
module i2cmem_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start,
    output logic stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cmem_ram.sv
module i2cmem_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        rdata <= cells[addr];
    end
endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
    import i2cmem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] chip_sel,
    input  logic       wp
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

    i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
    i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

    i2cmem_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start(start), .stop(stop));

    state_t            state, state_d, after_q, after_d;
    logic [2:0]        cnt_q, cnt_d;
    logic [7:0]        rx_q, rx_d, tx_q, tx_d;
    logic [HI_W-1:0]   hi_q, hi_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic              ack_q, ack_d, oe_q, oe_d;
    logic              ld_ptr, inc, wr_en;
    logic [7:0]        byte_in, rdata;
    logic              dev_ok, prot;

    assign byte_in = {rx_q[6:0], sda_s};
    assign dev_ok  = (byte_in[7:4] == SEL_CODE) && (byte_in[3:1] == chip_sel);
    assign prot    = wp && (ptr_q[ADDR_W-1 -: 2] == 2'b11);

    i2cmem_ram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk(clk), .addr(ptr_q), .we(wr_en), .wdata(byte_in), .rdata(rdata));

    // next-state and control decisions
    always_comb begin
        state_d = state;
        after_d = after_q;
        ack_d   = ack_q;
        oe_d    = oe_q;
        tx_d    = tx_q;
        rx_d    = rx_q;
        cnt_d   = cnt_q;
        hi_d    = hi_q;
        ld_ptr  = 1'b0;
        inc     = 1'b0;
        wr_en   = 1'b0;
        if (stop) begin
            state_d = S_IDLE;
            oe_d    = 1'b0;
        end else if (start) begin
            state_d = S_DEV;
            oe_d    = 1'b0;
            cnt_d   = 3'd0;
        end else begin
            unique case (state)
                S_DEV, S_AHI, S_ALO, S_WR: begin
                    if (scl_rise) begin
                        rx_d  = byte_in;
                        cnt_d = cnt_q + 3'd1;
                        if (cnt_q == 3'd7) begin
                            state_d = S_ACK1;
                            ack_d   = 1'b1;
                            if (state == S_DEV) begin
                                if (dev_ok) after_d = byte_in[0] ? S_RD : S_AHI;
                                else        state_d = S_IGN;
                            end else if (state == S_AHI) begin
                                hi_d    = byte_in[HI_W-1:0];
                                after_d = S_ALO;
                            end else if (state == S_ALO) begin
                                ld_ptr  = 1'b1;
                                after_d = S_WR;
                            end else if (prot) begin
                                ack_d   = 1'b0;
                                after_d = S_IGN;
                            end else begin
                                wr_en   = 1'b1;
                                inc     = 1'b1;
                                after_d = S_WR;
                            end
                        end
                    end
                end
                S_ACK1: if (scl_fall) begin
                    state_d = S_ACK2;
                    oe_d    = ack_q;
                end
                S_ACK2: if (scl_fall) begin
                    state_d = after_q;
                    if (after_q == S_RD) begin
                        tx_d  = rdata;
                        oe_d  = ~rdata[7];
                        cnt_d = 3'd0;
                    end else begin
                        oe_d = 1'b0;
                    end
                end
                S_RD: if (scl_fall) begin
                    cnt_d = cnt_q + 3'd1;
                    if (cnt_q == 3'd7) begin
                        state_d = S_RACK;
                        oe_d    = 1'b0;
                        inc     = 1'b1;
                    end else begin
                        tx_d = {tx_q[6:0], 1'b0};
                        oe_d = ~tx_q[6];
                    end
                end
                S_RACK: if (scl_rise) state_d = sda_s ? S_IGN : S_RLD;
                S_RLD: if (scl_fall) begin
                    state_d = S_RD;
                    tx_d    = rdata;
                    oe_d    = ~rdata[7];
                    cnt_d   = 3'd0;
                end
                default: ;
            endcase
        end
        if (ld_ptr)   ptr_d = {hi_q, byte_in};
        else if (inc) ptr_d = ptr_q + 1'b1;
        else          ptr_d = ptr_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            after_q <= S_IDLE;
            ack_q   <= 1'b0;
            oe_q    <= 1'b0;
            tx_q    <= '0;
            rx_q    <= '0;
            cnt_q   <= '0;
            hi_q    <= '0;
            ptr_q   <= '0;
        end else begin
            after_q <= after_d;
            ack_q   <= ack_d;
            oe_q    <= oe_d;
            tx_q    <= tx_d;
            rx_q    <= rx_d;
            cnt_q   <= cnt_d;
            hi_q    <= hi_d;
            ptr_q   <= ptr_d;
        end
    end

    assign sda_oe = oe_q;

    // R9: a new drive level appears only while SCL is low
    a_r9_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(sda_oe) && !$past(start) && !$past(stop)) |-> !scl_s);

    // R1: a rejected or finished transfer keeps the line released
    a_r1_silent_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGN) |-> !sda_oe);

    // R4: the line is free while the controller acknowledges
    a_r4_free_in_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RACK) |-> !sda_oe);

    // R3: the pointer either steps by one or is loaded by the address phase
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |->
        ((ptr_q == ADDR_W'($past(ptr_q) + 1'b1)) || ($past(state) == S_ALO)));

    // R7: a refused protected byte leaves the pointer still
    a_r7_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR && scl_rise && cnt_q == 3'd7 && prot && !start && !stop)
        |=> $stable(ptr_q));
endmodule

// File: tb/i2cmem_slave_test.sv
module i2cmem_slave_test;
    localparam int CLK_NS = 10;
    localparam int AW     = 11;
    localparam int DEPTH  = 1 << AW;
    localparam int H      = 10;
    localparam int SEED   = 1234;
    localparam int LIMIT  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       wp = 1'b0;
    logic [2:0] chip_sel = 3'b101;
    logic       sda_oe;
    logic       sda_line;

    assign sda_line = !(sda_oe || m_low);

    always #(CLK_NS / 2) clk = ~clk;

    i2cmem_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .chip_sel(chip_sel), .wp(wp));

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] mdl_mem [DEPTH];
    bit   mdl_known [DEPTH];
    int   mdl_ptr = 0;

    function automatic logic [7:0] sel_byte(bit rd, logic [2:0] cs);
        return {4'b1010, cs, rd};
    endfunction

    function automatic bit exp_ack(int p, bit w);
        return !(w && p >= (DEPTH / 4) * 3);
    endfunction

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_eq(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic m_start;
        m_low = 1'b0; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_low = 1'b1; wclk(H);
        m_scl = 1'b0; wclk(H);
    endtask

    task automatic m_stop;
        m_low = 1'b1; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_low = 1'b0; wclk(H);
    endtask

    task automatic m_bit(bit b);
        m_low = !b; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_scl = 1'b0; wclk(2);
    endtask

    task automatic m_wbyte(logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        m_low = 1'b0; wclk(H);
        m_scl = 1'b1; wclk(H / 2);
        ack = !sda_line; wclk(H / 2);
        m_scl = 1'b0; wclk(2);
    endtask

    task automatic m_rbyte(bit ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wclk(H);
            m_scl = 1'b1; wclk(H / 2);
            b[i] = sda_line; wclk(H / 2);
            m_scl = 1'b0; wclk(2);
        end
        m_low = ack; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_scl = 1'b0; wclk(2);
        m_low = 1'b0;
    endtask

    task automatic set_addr(int a, logic [7:0] junk);
        bit ack;
        logic [7:0] hi;
        hi = 8'((a >> 8) & ((1 << (AW - 8)) - 1)) | (junk & ~8'((1 << (AW - 8)) - 1));
        m_start;
        m_wbyte(sel_byte(1'b0, chip_sel), ack);
        chk_eq("R1 select ack", int'(ack), 1);
        m_wbyte(hi, ack);
        chk_eq("R2 upper address ack", int'(ack), 1);
        m_wbyte(8'(a), ack);
        chk_eq("R2 lower address ack", int'(ack), 1);
        mdl_ptr = a % DEPTH;
    endtask

    task automatic write_body(int n, output int stored);
        bit ack;
        logic [7:0] d;
        stored = 0;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            m_wbyte(d, ack);
            if (exp_ack(mdl_ptr, wp)) begin
                chk_eq("R3 data ack", int'(ack), 1);
                mdl_mem[mdl_ptr] = d;
                mdl_known[mdl_ptr] = 1'b1;
                mdl_ptr = (mdl_ptr + 1) % DEPTH;
                stored++;
            end else begin
                chk_eq("R7 protected byte nack", int'(ack), 0);
                break;
            end
        end
    endtask

    task automatic write_seq(int a, int n, logic [7:0] junk, output int stored);
        set_addr(a, junk);
        write_body(n, stored);
        m_stop;
    endtask

    task automatic read_seq(bit rnd, int a, int n);
        bit ack;
        logic [7:0] b;
        if (rnd) set_addr(a, 8'h00);
        m_start;
        m_wbyte(sel_byte(1'b1, chip_sel), ack);
        chk_eq("R1 read select ack", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            m_rbyte(k < n - 1, b);
            if (mdl_known[mdl_ptr])
                chk_eq("R4 read data", int'(b), int'(mdl_mem[mdl_ptr]));
            mdl_ptr = (mdl_ptr + 1) % DEPTH;
        end
        wclk(H);
        chk_eq("R4 released after nack", int'(sda_oe), 0);
        m_stop;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int stored;
        bit ack;
        logic [7:0] tmp;
        void'($urandom(SEED));
        for (int i = 0; i < DEPTH; i++) mdl_known[i] = 1'b0;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        chk_eq("R9 released after reset", int'(sda_oe), 0);

        // sequential write, random read, then current-address read
        write_seq(16, 8, 8'h00, stored);
        read_seq(1'b1, 16, 4);
        read_seq(1'b0, 0, 2);

        // wrong chip select: nack, later bytes ignored, pointer kept (R1)
        m_start;
        m_wbyte(sel_byte(1'b0, chip_sel ^ 3'b010), ack);
        chk_eq("R1 foreign select nack", int'(ack), 0);
        m_wbyte(8'h00, ack);
        chk_eq("R1 ignored byte nack", int'(ack), 0);
        m_wbyte(8'h33, ack);
        chk_eq("R1 ignored byte nack", int'(ack), 0);
        m_stop;
        read_seq(1'b0, 0, 1);

        // upper address bits ignored (R2)
        write_seq(12'h123, 2, 8'hE0, stored);
        read_seq(1'b1, 12'h123, 2);

        // wraparound (R3)
        write_seq(DEPTH - 2, 3, 8'h00, stored);
        read_seq(1'b1, DEPTH - 2, 3);

        // write protection (R7)
        write_seq(DEPTH * 3 / 4 - 2, 4, 8'h00, stored);
        wp = 1'b1;
        write_seq(DEPTH * 3 / 4 - 1, 3, 8'h00, stored);
        chk_eq("R7 bytes stored before boundary", stored, 1);
        read_seq(1'b0, 0, 1);
        wp = 1'b0;
        write_seq(DEPTH * 3 / 4, 1, 8'h00, stored);
        chk_eq("R7 writable with wp low", stored, 1);
        read_seq(1'b1, DEPTH * 3 / 4, 1);

        // select acknowledged right after a write (R8)
        set_addr(40, 8'h00);
        write_body(1, stored);
        m_start;
        m_wbyte(sel_byte(1'b0, chip_sel), ack);
        chk_eq("R8 select after write", int'(ack), 1);
        m_stop;

        // aborted bytes (R6): Stop after 5 bits, Start after 3 bits
        set_addr(16, 8'h00);
        tmp = ~mdl_mem[16];
        for (int i = 7; i >= 3; i--) m_bit(tmp[i]);
        m_stop;
        read_seq(1'b0, 0, 1);
        chk_eq("R6 pointer after stop abort", mdl_ptr, 17);
        set_addr(17, 8'h00);
        tmp = ~mdl_mem[17];
        for (int i = 7; i >= 5; i--) m_bit(tmp[i]);
        m_start;
        m_stop;
        read_seq(1'b0, 0, 1);
        chk_eq("R6 pointer after start abort", mdl_ptr, 18);

        // constrained random bursts (R3, R4, R5, R7)
        for (int it = 0; it < 16; it++) begin
            int a, n;
            a  = int'($urandom % DEPTH);
            n  = 1 + int'($urandom % 5);
            wp = ($urandom % 4) == 0;
            write_seq(a, n, 8'($urandom), stored);
            wp = 1'b0;
            if (stored > 0) read_seq(1'b1, a, stored);
            else read_seq(1'b0, 0, 1);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule